// File: doc/BRIEF.md
# Command Queue Thread Register Block

This block holds the control and status registers for a set of hardware execution threads inside a command-queue engine. A host reaches every register over a plain 32-bit read/write bus. A small global area sits at the bottom of the map, and above it each thread has its own fixed-size window. Through that window the host can warm-reset a thread, enable it, pause and resume it, load its fetch and end pointers, set its priority, and arm or clear its interrupt sources. It can also see whether the thread is blocked on an event.

The execution datapath is outside this block. It is represented by per-thread status inputs: completion and error pulses, an idle indication, a waiting flag and a pointer-advance strobe. The block combines the per-thread interrupt lines into a chip-level summary in which a pending thread shows as a 0. A write to the token-clear register sends a one-cycle event-ID strobe to the event logic.

Top module: `cq_thread_regs`

## Requirements
- R1: After reset, every thread register reads 0, the global slot-cycle register at 0x030 reads 0x3200, and the global summary at 0x010 reads 1 in each of the NUM_THR low bits with every irq_sum_n bit high.
- R2: Thread t owns addresses 0x100 + 0x80*t through 0x17F + 0x80*t. Within the window, the enable register at 0x04 bit 0, the suspend register at 0x08 bit 0, the fetch pointer at 0x20, the end pointer at 0x24, the priority at 0x40 (low PRIO_W bits) and the interrupt enable at 0x14 (bits 0, 1 and 4 only) all read back what was written.
- R3: An address that maps to no register reads 0, and a write to it changes no register. This covers unused window offsets, addresses above the last thread window and unused global offsets.
- R4: Writing 1 to bit 0 of thread offset 0x00 starts a warm reset. That bit reads 1 for RST_CYCLES cycles after the write and then reads 0. The reset clears enable, suspend, suspend status, interrupt status and both pointers, and keeps priority and interrupt enable.
- R5: Bit 1 of thread status at 0x0C becomes 1 on the write that sets suspend if the thread is disabled or eng_idle is high. Otherwise it becomes 1 on the first edge where eng_idle is high. Writing 0 to suspend clears it on that write.
- R6: eng_done, eng_err_op and eng_err_fetch set interrupt-status bits 0, 1 and 4 at offset 0x10, each only when the matching interrupt-enable bit is 1.
- R7: A write to interrupt status keeps each bit written as 1 and clears each bit written as 0. An event arriving on the same edge still sets its bit.
- R8: Summary bit t, at global 0x010 and on irq_sum_n[t], is 0 exactly when thread t has a status bit that is also enabled. irq_any is high when any thread has such a bit.
- R9: Thread offset 0x30 reads eng_wait of that thread in bit 31 and 0 in all other bits.
- R10: An eng_step pulse advances the fetch pointer by 8 >> ADDR_SHIFT units. A host write to the pointer on the same edge takes precedence.
- R11: The slot-cycle register at global 0x030 is readable and writable over all 32 bits.
- R12: A write to global 0x068 drives tok_clr_vld high for the following cycle only, with tok_clr_id set to the low TOK_W data bits. The register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| eng_done | input | NUM_THR | Completion pulse per thread |
| eng_err_op | input | NUM_THR | Instruction error pulse per thread |
| eng_err_fetch | input | NUM_THR | Fetch error pulse per thread |
| eng_idle | input | NUM_THR | Thread is at an instruction boundary |
| eng_wait | input | NUM_THR | Thread is blocked on an event |
| eng_step | input | NUM_THR | Fetch pointer advance strobe |
| irq_sum_n | output | NUM_THR | Per-thread interrupt summary, low when pending |
| irq_any | output | 1 | Any thread has a pending interrupt |
| tok_clr_vld | output | 1 | Token-clear strobe |
| tok_clr_id | output | TOK_W | Event ID to clear |

## Verification
If a thread's interrupt status or enable held the wrong value, it would show on irq_sum_n and irq_any in the same cycle, and on the next read of the summary register. A warm-reset counter that is off by one changes the exact cycle on which bit 0 of 0x00 drops, so the bench samples that bit on every cycle. A wrong window decode would send a write to a neighbouring thread or drop it. That shows up as a wrong readback or as a non-zero read from an unmapped address on the next access.

// File: rtl/cq_regs_pkg.sv
package cq_regs_pkg;
   // thread window offsets (low 7 address bits)
   localparam logic [6:0] OFF_WRST = 7'h00;
   localparam logic [6:0] OFF_EN   = 7'h04;
   localparam logic [6:0] OFF_SUSP = 7'h08;
   localparam logic [6:0] OFF_STAT = 7'h0C;
   localparam logic [6:0] OFF_ISTA = 7'h10;
   localparam logic [6:0] OFF_IEN  = 7'h14;
   localparam logic [6:0] OFF_CUR  = 7'h20;
   localparam logic [6:0] OFF_END  = 7'h24;
   localparam logic [6:0] OFF_WAIT = 7'h30;
   localparam logic [6:0] OFF_PRIO = 7'h40;
   // global offsets (low 8 address bits, below the first window)
   localparam logic [7:0] GOFF_SUM  = 8'h10;
   localparam logic [7:0] GOFF_SLOT = 8'h30;
   localparam logic [7:0] GOFF_TOK  = 8'h68;
   // interrupt bit layout
   localparam logic [4:0] IRQ_MASK = 5'b1_0011;
   localparam int WIN_BASE = 'h100;
   localparam int WIN_SHIFT = 7;
   localparam int INST_BYTES = 8;
endpackage

// File: rtl/cq_thr_slot.sv
module cq_thr_slot
   import cq_regs_pkg::*;
#(
   parameter int ADDR_SHIFT = 3,
   parameter int RST_CYCLES = 4,
   parameter int PRIO_W     = 3
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        sel,
   input  logic        wr,
   input  logic [6:0]  off,
   input  logic [31:0] wdata,
   input  logic        eng_done,
   input  logic        eng_err_op,
   input  logic        eng_err_fetch,
   input  logic        eng_idle,
   input  logic        eng_wait,
   input  logic        eng_step,
   output logic [31:0] rdata,
   output logic        irq_line
);
   localparam int STEP  = INST_BYTES >> ADDR_SHIFT;
   localparam int CNT_W = $clog2(RST_CYCLES + 1);

   logic              rst_busy;
   logic [CNT_W-1:0]  rst_cnt;
   logic              en_q, susp_req, susp_done;
   logic [4:0]        ista_q, ien_q;
   logic [31:0]       cur_q, end_q;
   logic [PRIO_W-1:0] prio_q;

   logic wr_go, start_rst, susp_nxt;
   logic [4:0] evt;

   assign wr_go     = sel && wr;
   assign start_rst = wr_go && (off == OFF_WRST) && wdata[0] && !rst_busy;
   assign susp_nxt  = (wr_go && off == OFF_SUSP) ? wdata[0] : susp_req;
   assign evt       = rst_busy ? 5'b0 :
                      ({eng_err_fetch, 2'b00, eng_err_op, eng_done} & ien_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_busy  <= 1'b0;
         rst_cnt   <= '0;
         en_q      <= 1'b0;
         susp_req  <= 1'b0;
         susp_done <= 1'b0;
         ista_q    <= '0;
         ien_q     <= '0;
         cur_q     <= '0;
         end_q     <= '0;
         prio_q    <= '0;
      end else begin
         if (start_rst) begin
            rst_busy <= 1'b1;
            rst_cnt  <= CNT_W'(RST_CYCLES);
         end else if (rst_busy) begin
            if (rst_cnt == CNT_W'(1)) rst_busy <= 1'b0;
            rst_cnt <= rst_cnt - CNT_W'(1);
         end

         if (start_rst) begin
            en_q      <= 1'b0;
            susp_req  <= 1'b0;
            susp_done <= 1'b0;
            ista_q    <= '0;
            cur_q     <= '0;
            end_q     <= '0;
         end else begin
            if (wr_go && off == OFF_EN) en_q <= wdata[0];
            susp_req  <= susp_nxt;
            susp_done <= susp_nxt && (susp_done || !en_q || eng_idle);
            ista_q    <= ((wr_go && off == OFF_ISTA) ? (ista_q & wdata[4:0]) : ista_q) | evt;
            if (wr_go && off == OFF_CUR)           cur_q <= wdata;
            else if (eng_step && !rst_busy)        cur_q <= cur_q + 32'(STEP);
            if (wr_go && off == OFF_END)           end_q <= wdata;
         end
         if (wr_go && off == OFF_IEN)  ien_q  <= wdata[4:0] & IRQ_MASK;
         if (wr_go && off == OFF_PRIO) prio_q <= wdata[PRIO_W-1:0];
      end
   end

   always_comb begin
      case (off)
         OFF_WRST: rdata = {31'b0, rst_busy};
         OFF_EN:   rdata = {31'b0, en_q};
         OFF_SUSP: rdata = {31'b0, susp_req};
         OFF_STAT: rdata = {30'b0, susp_done, 1'b0};
         OFF_ISTA: rdata = {27'b0, ista_q};
         OFF_IEN:  rdata = {27'b0, ien_q};
         OFF_CUR:  rdata = cur_q;
         OFF_END:  rdata = end_q;
         OFF_WAIT: rdata = {eng_wait, 31'b0};
         OFF_PRIO: rdata = 32'(prio_q);
         default:  rdata = 32'b0;
      endcase
   end

   assign irq_line = |(ista_q & ien_q);

   // R4
   wrst_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_rst |=> (rst_busy && !en_q && ista_q == 5'b0 && cur_q == 32'b0));
   // R5
   susp_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      susp_done |-> susp_req);
   // R6
   masked_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ista_q & ~$past(ista_q) & ~$past(ien_q)) == 5'b0);
   // R7
   ista_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_go && off == OFF_ISTA && evt == 5'b0 && !start_rst)
      |=> ((ista_q & ~$past(wdata[4:0])) == 5'b0));
endmodule

// File: rtl/cq_gbl_regs.sv
module cq_gbl_regs
   import cq_regs_pkg::*;
#(
   parameter int          NUM_THR   = 16,
   parameter int          TOK_W     = 10,
   parameter logic [31:0] SLOT_INIT = 32'h3200
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sel,
   input  logic               wr,
   input  logic [7:0]         off,
   input  logic [31:0]        wdata,
   input  logic [NUM_THR-1:0] sum_n,
   output logic [31:0]        rdata,
   output logic               tok_clr_vld,
   output logic [TOK_W-1:0]   tok_clr_id
);
   logic [31:0] slot_q;
   logic        tok_wr;

   assign tok_wr = sel && wr && (off == GOFF_TOK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q      <= SLOT_INIT;
         tok_clr_vld <= 1'b0;
         tok_clr_id  <= '0;
      end else begin
         if (sel && wr && off == GOFF_SLOT) slot_q <= wdata;
         tok_clr_vld <= tok_wr;
         if (tok_wr) tok_clr_id <= wdata[TOK_W-1:0];
      end
   end

   always_comb begin
      case (off)
         GOFF_SUM:  rdata = 32'(sum_n);
         GOFF_SLOT: rdata = slot_q;
         default:   rdata = 32'b0;
      endcase
   end

   // R12
   tok_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tok_clr_vld |-> $past(sel && wr && off == GOFF_TOK));
endmodule

// File: rtl/cq_thread_regs.sv
module cq_thread_regs
   import cq_regs_pkg::*;
#(
   parameter int NUM_THR    = 16,
   parameter int ADDR_W     = 12,
   parameter int ADDR_SHIFT = 3,
   parameter int RST_CYCLES = 4,
   parameter int PRIO_W     = 3,
   parameter int TOK_W      = 10
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_sel,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   input  logic [NUM_THR-1:0] eng_done,
   input  logic [NUM_THR-1:0] eng_err_op,
   input  logic [NUM_THR-1:0] eng_err_fetch,
   input  logic [NUM_THR-1:0] eng_idle,
   input  logic [NUM_THR-1:0] eng_wait,
   input  logic [NUM_THR-1:0] eng_step,
   output logic [NUM_THR-1:0] irq_sum_n,
   output logic               irq_any,
   output logic               tok_clr_vld,
   output logic [TOK_W-1:0]   tok_clr_id
);
   localparam int IDX_W  = ADDR_W - WIN_SHIFT;
   localparam int MAP_HI = WIN_BASE + (NUM_THR << WIN_SHIFT);

   if (ADDR_SHIFT != 0 && ADDR_SHIFT != 3) begin : g_bad_shift
      $error("ADDR_SHIFT must be 0 or 3");
   end
   if (NUM_THR < 1 || NUM_THR > 32) begin : g_bad_thr
      $error("NUM_THR must be 1..32");
   end
   if (MAP_HI > (1 << ADDR_W)) begin : g_bad_map
      $error("thread windows exceed the address space");
   end
   if (RST_CYCLES < 1 || TOK_W < 1 || TOK_W > 32 || PRIO_W < 1 || PRIO_W > 32) begin : g_bad_misc
      $error("bad RST_CYCLES, TOK_W or PRIO_W");
   end

   logic [ADDR_W-1:0]  rel;
   logic [IDX_W-1:0]   idx;
   logic               gbl_hit, thr_hit;
   logic [NUM_THR-1:0] thr_sel, thr_irq;
   logic [31:0]        thr_rd [NUM_THR];
   logic [31:0]        gbl_rd;

   assign rel     = bus_addr - ADDR_W'(WIN_BASE);
   assign idx     = rel[ADDR_W-1:WIN_SHIFT];
   assign gbl_hit = (32'(bus_addr) < WIN_BASE);
   assign thr_hit = !gbl_hit && (32'(bus_addr) < MAP_HI);

   for (genvar g = 0; g < NUM_THR; g++) begin : g_thr
      assign thr_sel[g] = bus_sel && thr_hit && (idx == IDX_W'(g));
      cq_thr_slot #(
         .ADDR_SHIFT(ADDR_SHIFT), .RST_CYCLES(RST_CYCLES), .PRIO_W(PRIO_W)
      ) u_slot (
         .clk(clk), .rst_n(rst_n), .sel(thr_sel[g]), .wr(bus_wr),
         .off(rel[WIN_SHIFT-1:0]), .wdata(bus_wdata),
         .eng_done(eng_done[g]), .eng_err_op(eng_err_op[g]),
         .eng_err_fetch(eng_err_fetch[g]), .eng_idle(eng_idle[g]),
         .eng_wait(eng_wait[g]), .eng_step(eng_step[g]),
         .rdata(thr_rd[g]), .irq_line(thr_irq[g])
      );
   end

   assign irq_sum_n = ~thr_irq;
   assign irq_any   = |thr_irq;

   cq_gbl_regs #(.NUM_THR(NUM_THR), .TOK_W(TOK_W)) u_gbl (
      .clk(clk), .rst_n(rst_n), .sel(bus_sel && gbl_hit), .wr(bus_wr),
      .off(bus_addr[7:0]), .wdata(bus_wdata), .sum_n(irq_sum_n),
      .rdata(gbl_rd), .tok_clr_vld(tok_clr_vld), .tok_clr_id(tok_clr_id)
   );

   always_comb begin
      bus_rdata = gbl_hit ? gbl_rd : 32'b0;
      for (int i = 0; i < NUM_THR; i++)
         if (thr_sel[i]) bus_rdata = bus_rdata | thr_rd[i];
   end

   // R8
   summary_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_any == !(&irq_sum_n));
   // R2
   one_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(thr_sel));
endmodule

// File: tb/cq_thread_regs_test.sv
`timescale 1ns/1ps
module cq_thread_regs_test;
   localparam int N = 16;
   logic clk = 0, rst_n = 0;
   logic bus_sel = 0, bus_wr = 0;
   logic [11:0] bus_addr = 0;
   logic [31:0] bus_wdata = 0, bus_rdata;
   logic [N-1:0] eng_done = 0, eng_err_op = 0, eng_err_fetch = 0;
   logic [N-1:0] eng_idle = 0, eng_wait = 0, eng_step = 0;
   logic [N-1:0] irq_sum_n;
   logic irq_any, tok_clr_vld;
   logic [9:0] tok_clr_id;
   int n_chk = 0, n_bad = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   cq_thread_regs uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .eng_done(eng_done), .eng_err_op(eng_err_op), .eng_err_fetch(eng_err_fetch),
      .eng_idle(eng_idle), .eng_wait(eng_wait), .eng_step(eng_step),
      .irq_sum_n(irq_sum_n), .irq_any(irq_any),
      .tok_clr_vld(tok_clr_vld), .tok_clr_id(tok_clr_id));

   function automatic logic [11:0] ta(int t, int o);
      return 12'(32'h100 + t * 32'h80 + o);
   endfunction

   task automatic check(string req, logic [31:0] got, logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic wr(logic [11:0] a, logic [31:0] d);
      bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(posedge clk); @(negedge clk);
      bus_sel = 0; bus_wr = 0;
   endtask

   task automatic rd(logic [11:0] a, output logic [31:0] d);
      bus_sel = 1; bus_wr = 0; bus_addr = a;
      #1 d = bus_rdata;
      bus_sel = 0;
   endtask

   task automatic rdchk(string req, logic [11:0] a, logic [31:0] exp);
      logic [31:0] d;
      rd(a, d);
      check(req, d, exp);
   endtask

   task automatic tick();
      @(posedge clk); @(negedge clk);
   endtask

   // {req(4), is_write(1), addr(12), data(32)}
   localparam int NV = 16;
   localparam logic [48:0] VEC [NV] = '{
      {4'd1,  1'b0, 12'h030, 32'h0000_3200},  // R1 slot reset value
      {4'd2,  1'b1, 12'h140, 32'hFFFF_FFFF},  // R2 thread0 priority
      {4'd2,  1'b0, 12'h140, 32'h0000_0007},
      {4'd2,  1'b1, 12'h8A0, 32'h1234_5678},  // R2 thread15 fetch ptr
      {4'd2,  1'b0, 12'h8A0, 32'h1234_5678},
      {4'd2,  1'b1, 12'h2A4, 32'h0000_0ABC},  // R2 thread3 end ptr
      {4'd2,  1'b0, 12'h2A4, 32'h0000_0ABC},
      {4'd2,  1'b1, 12'h214, 32'h0000_00FF},  // R2 thread2 irq enable
      {4'd2,  1'b0, 12'h214, 32'h0000_0013},
      {4'd3,  1'b1, 12'h19C, 32'h0000_0005},  // R3 unused window slot
      {4'd3,  1'b0, 12'h19C, 32'h0000_0000},
      {4'd3,  1'b1, 12'hA00, 32'h0000_0005},  // R3 beyond last thread
      {4'd3,  1'b0, 12'h900, 32'h0000_0000},
      {4'd11, 1'b1, 12'h030, 32'h0000_0055},  // R11 slot write
      {4'd11, 1'b0, 12'h030, 32'h0000_0055},
      {4'd12, 1'b0, 12'h068, 32'h0000_0000}   // R12 reads 0
   };

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      check("R1 sum_n", 32'(irq_sum_n), 32'h0000_FFFF);
      check("R1 irq_any", 32'(irq_any), 32'h0);
      rdchk("R1 gsum", 12'h010, 32'h0000_FFFF);
      rdchk("R1 en", ta(0, 'h04), 32'h0);
      rdchk("R1 cur", ta(9, 'h20), 32'h0);

      for (int i = 0; i < NV; i++) begin
         if (VEC[i][44]) wr(VEC[i][43:32], VEC[i][31:0]);
         else begin
            rd(VEC[i][43:32], d);
            check($sformatf("R%0d vec%0d", VEC[i][48:45], i), d, VEC[i][31:0]);
         end
      end
      // R3: writing an unused global offset leaves the slot register intact
      wr(12'h040, 32'h7);
      rdchk("R3 gbl unused", 12'h040, 32'h0);
      rdchk("R3 slot intact", 12'h030, 32'h55);
      rdchk("R3 thr2 ien intact", ta(2, 'h14), 32'h13);
      // R2 enable
      wr(ta(0, 'h04), 32'h1);
      rdchk("R2 en", ta(0, 'h04), 32'h1);

      // R6 masking
      wr(ta(5, 'h14), 32'h01);
      eng_err_op[5] = 1; tick(); eng_err_op[5] = 0;
      rdchk("R6 masked err", ta(5, 'h10), 32'h0);
      check("R8 no pend", 32'(irq_sum_n[5]), 32'h1);
      eng_done[5] = 1; tick(); eng_done[5] = 0;
      rdchk("R6 done", ta(5, 'h10), 32'h01);
      check("R8 sum_n", 32'(irq_sum_n), 32'h0000_FFDF);
      check("R8 any", 32'(irq_any), 32'h1);
      rdchk("R8 gsum", 12'h010, 32'h0000_FFDF);
      wr(ta(5, 'h14), 32'h13);
      eng_err_op[5] = 1; eng_err_fetch[5] = 1; tick();
      eng_err_op[5] = 0; eng_err_fetch[5] = 0;
      rdchk("R6 errs", ta(5, 'h10), 32'h13);
      // R7 write-0-clears
      wr(ta(5, 'h10), 32'h10);
      rdchk("R7 keep1", ta(5, 'h10), 32'h10);
      bus_sel = 1; bus_wr = 1; bus_addr = ta(5, 'h10); bus_wdata = 0;
      eng_done[5] = 1; tick();
      bus_sel = 0; bus_wr = 0; eng_done[5] = 0;
      rdchk("R7 evt wins", ta(5, 'h10), 32'h01);
      // R8 enable masks summary
      wr(ta(5, 'h14), 32'h0);
      check("R8 masked", 32'(irq_sum_n), 32'h0000_FFFF);
      rdchk("R8 sta held", ta(5, 'h10), 32'h01);
      wr(ta(5, 'h10), 32'h0);
      rdchk("R7 cleared", ta(5, 'h10), 32'h0);

      // R9 wait flag
      eng_wait[7] = 1; #1;
      rdchk("R9 wait", ta(7, 'h30), 32'h8000_0000);
      rdchk("R9 other", ta(6, 'h30), 32'h0);
      eng_wait[7] = 0;

      // R10 pointer step (step = 1 unit with shift 3)
      wr(ta(4, 'h20), 32'h100);
      eng_step[4] = 1; tick(); tick(); tick(); eng_step[4] = 0;
      rdchk("R10 step", ta(4, 'h20), 32'h103);
      bus_sel = 1; bus_wr = 1; bus_addr = ta(4, 'h20); bus_wdata = 32'h40;
      eng_step[4] = 1; tick();
      bus_sel = 0; bus_wr = 0; eng_step[4] = 0;
      rdchk("R10 host wins", ta(4, 'h20), 32'h40);

      // R5 suspend
      wr(ta(8, 'h08), 32'h1);
      rdchk("R5 disabled", ta(8, 'h0C), 32'h2);
      wr(ta(8, 'h08), 32'h0);
      rdchk("R5 resume", ta(8, 'h0C), 32'h0);
      wr(ta(9, 'h04), 32'h1);
      wr(ta(9, 'h08), 32'h1);
      tick(); tick();
      rdchk("R5 busy", ta(9, 'h0C), 32'h0);
      eng_idle[9] = 1; tick();
      rdchk("R5 idle", ta(9, 'h0C), 32'h2);
      rdchk("R5 req", ta(9, 'h08), 32'h1);
      eng_idle[9] = 0;

      // R4 warm reset
      wr(ta(10, 'h04), 32'h1);
      wr(ta(10, 'h20), 32'h55);
      wr(ta(10, 'h40), 32'h5);
      wr(ta(10, 'h14), 32'h13);
      eng_done[10] = 1; tick(); eng_done[10] = 0;
      wr(ta(10, 'h00), 32'h1);
      for (int k = 0; k < 4; k++) begin
         rdchk($sformatf("R4 busy%0d", k), ta(10, 'h00), 32'h1);
         tick();
      end
      rdchk("R4 done", ta(10, 'h00), 32'h0);
      rdchk("R4 en", ta(10, 'h04), 32'h0);
      rdchk("R4 cur", ta(10, 'h20), 32'h0);
      rdchk("R4 sta", ta(10, 'h10), 32'h0);
      rdchk("R4 prio", ta(10, 'h40), 32'h5);
      rdchk("R4 ien", ta(10, 'h14), 32'h13);

      // R12 token clear strobe
      wr(12'h068, 32'hFFFF_F2AB);
      check("R12 vld", 32'(tok_clr_vld), 32'h1);
      check("R12 id", 32'(tok_clr_id), 32'h2AB);
      tick();
      check("R12 pulse", 32'(tok_clr_vld), 32'h0);

      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog got=%h exp=%h", 0, 1);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule